// File: doc/BRIEF.md
# Branch Condition Evaluator

This combinational block decides whether a conditional instruction is taken. It receives a 4-bit condition selector and five status flags: zero, sign, overflow, carry and a sticky saturation flag. From these it produces one "condition true" bit. That bit drives two consumers at once:

- the next-PC selection for a conditional branch;
- a 32-bit value for a set-on-condition operation, which writes exactly 0 or 1 to a destination register.

The block also sign-extends a 9-bit branch displacement. When the condition holds, the next PC is the current PC plus the extended displacement. When it does not hold, the next PC is the current PC plus the fall-through step of 2.

The status flags are inputs only. Evaluation never changes them. Fetch, decode and the register file are outside the block. The decode stage applies the selector, flags, PC and displacement. It then takes whichever result it needs in the same cycle.

Top module: `cond_eval`

## Requirements
- R1: Codes 0, 1, 2, 3 and 4 are true when, respectively, overflow is set, carry is set, zero is set, carry OR zero is set, and sign is set.
- R2: Code 5 is always true, whatever the flags.
- R3: Code 6 is true when sign XOR overflow is 1. Code 7 is true when (sign XOR overflow) OR zero is 1.
- R4: Codes 8, 9, 10, 11, 12, 14 and 15 are the exact complements of codes 0, 1, 2, 3, 4, 6 and 7 respectively.
- R5: Code 13 is true exactly when the saturation flag is set. The other four flags do not affect it.
- R6: The saturation flag has no effect on any code other than 13.
- R7: The set-on-condition value is 32'h00000001 when the condition is true and 32'h00000000 otherwise.
- R8: The extended displacement copies bit 8 of the 9-bit field into bits 31 to 9, and keeps bits 8 to 0 unchanged.
- R9: The next PC is PC plus the extended displacement when the condition is true, and PC plus 2 when it is false. Both sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_sel | input | 4 | Condition selector, encoded as in R1 to R5 |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_ov | input | 1 | Overflow flag |
| flag_cy | input | 1 | Carry flag |
| flag_sat | input | 1 | Sticky saturation flag |
| pc | input | 32 | Address of the current instruction |
| disp | input | 9 | Raw signed branch displacement |
| taken | output | 1 | Condition true |
| set_val | output | 32 | Value for the set-on-condition destination |
| disp_ext | output | 32 | Sign-extended displacement |
| next_pc | output | 32 | Selected next PC |

## Verification
The branch target selection and the set-on-condition value come from the same evaluation in the same cycle. A fault in the shared condition therefore shows up in both outputs together. A fault in either output path shows up in only one of them.

Each vector applies a selector and flag pattern together with a random PC and displacement. It then compares the taken bit, the 32-bit set value and the next PC against a bench reference. The stimulus covers every selector against all 32 flag combinations, which includes the saturation flag toggling under the non-saturation codes. Directed cases add negative and extreme displacements and a PC near the top of the address space, so that the wrapping sums are exercised.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 9,
  parameter int STEP   = 2
) (
  input  logic [3:0]        cond_sel,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_ov,
  input  logic              flag_cy,
  input  logic              flag_sat,
  input  logic [DATA_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic              taken,
  output logic [DATA_W-1:0] set_val,
  output logic [DATA_W-1:0] disp_ext,
  output logic [DATA_W-1:0] next_pc
);
  localparam int EXT_W = DATA_W - DISP_W;
  localparam logic [3:0] SAT_SEL = 4'd13;

  logic lt, base;

  assign lt = flag_s ^ flag_ov;

  always_comb begin
    case (cond_sel[2:0])
      3'd0:    base = flag_ov;
      3'd1:    base = flag_cy;
      3'd2:    base = flag_z;
      3'd3:    base = flag_cy | flag_z;
      3'd4:    base = flag_s;
      3'd5:    base = 1'b1;
      3'd6:    base = lt;
      default: base = lt | flag_z;
    endcase
  end

  assign taken    = (cond_sel == SAT_SEL) ? flag_sat : (base ^ cond_sel[3]);
  assign set_val  = {{(DATA_W-1){1'b0}}, taken};
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign next_pc  = pc + (taken ? disp_ext : DATA_W'(STEP));
endmodule

module cond_eval_chk #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 9,
  parameter int STEP   = 2
) (
  input logic [3:0]        cond_sel,
  input logic              flag_z,
  input logic              flag_s,
  input logic              flag_ov,
  input logic              flag_cy,
  input logic              flag_sat,
  input logic [DATA_W-1:0] pc,
  input logic [DISP_W-1:0] disp,
  input logic              taken,
  input logic [DATA_W-1:0] set_val,
  input logic [DATA_W-1:0] disp_ext,
  input logic [DATA_W-1:0] next_pc
);
  always_comb begin
    if (cond_sel == 4'd5) p_always_r2: assert (taken);
    if (cond_sel == 4'd13) p_sat_r5: assert (taken == flag_sat);
    if (cond_sel == 4'd2) p_zero_r1: assert (taken == flag_z);
    p_setval_r7: assert ($countones(set_val) == (taken ? 1 : 0) && set_val[0] == taken);
    p_sext_r8: assert (disp_ext[DISP_W-1:0] == disp &&
                       $countones(disp_ext[DATA_W-1:DISP_W-1]) ==
                       (disp[DISP_W-1] ? DATA_W-DISP_W+1 : 0));
    p_npc_r9: assert (next_pc - pc == (taken ? disp_ext : DATA_W'(STEP)));
  end
endmodule

bind cond_eval cond_eval_chk #(.DATA_W(DATA_W), .DISP_W(DISP_W), .STEP(STEP)) u_chk (.*);

// File: tb/cond_eval_bench.sv
`timescale 1ns/1ps
module cond_eval_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  cond_sel;
  logic        flag_z, flag_s, flag_ov, flag_cy, flag_sat;
  logic [31:0] pc;
  logic [8:0]  disp;
  logic        taken;
  logic [31:0] set_val, disp_ext, next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cond_eval u_cond_eval (.*);

  function automatic bit ref_cond(input logic [3:0] c, input logic [4:0] f);
    bit z, s, ov, cy, sat;
    {sat, cy, ov, s, z} = f;
    case (c)
      4'd0:  return ov;                  // R1
      4'd1:  return cy;
      4'd2:  return z;
      4'd3:  return cy | z;
      4'd4:  return s;
      4'd5:  return 1'b1;                // R2
      4'd6:  return s ^ ov;              // R3
      4'd7:  return (s ^ ov) | z;
      4'd13: return sat;                 // R5
      default: return !ref_cond(c - 4'd8, f); // R4
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h sel=%0d flags=%b", tag, act, exp, cond_sel,
               {flag_sat, flag_cy, flag_ov, flag_s, flag_z});
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [4:0] f,
                       input logic [31:0] p, input logic [8:0] d);
    bit t;
    logic [31:0] ext;
    @(negedge clk);
    cond_sel = c;
    {flag_sat, flag_cy, flag_ov, flag_s, flag_z} = f;
    pc = p;
    disp = d;
    #1;
    t = ref_cond(c, f);
    ext = {{23{d[8]}}, d};
    chk(c == 4'd13 ? "R5" : (c[3] ? "R4" : (c == 4'd5 ? "R2" : "R1/R3")), 32'(taken), 32'(t));
    chk("R7", set_val, t ? 32'd1 : 32'd0);
    chk("R8", disp_ext, ext);
    chk("R9", next_pc, p + (t ? ext : 32'd2));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    // reset-like quiescent state
    apply(4'd0, 5'b0, 32'h0, 9'h0);
    chk("R9", next_pc, 32'd2);
    // exhaustive selector x flags (R1..R6), random pc/disp
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        apply(4'(c), 5'(f), $urandom, 9'($urandom));
    // R6: saturation toggled under every other code, same other flags
    for (int c = 0; c < 16; c++) begin
      logic [4:0] f = 5'($urandom) & 5'h0f;
      bit a;
      if (c == 13) continue;
      apply(4'(c), f, 32'h100, 9'h4);
      a = taken;
      apply(4'(c), f | 5'h10, 32'h100, 9'h4);
      chk("R6", 32'(taken), 32'(a));
    end
    // R8/R9 displacement corners
    apply(4'd5, 5'b0, 32'h1000, 9'h100);
    chk("R9", next_pc, 32'h0F00);
    apply(4'd5, 5'b0, 32'h1000, 9'h0FF);
    chk("R9", next_pc, 32'h10FF);
    apply(4'd5, 5'b0, 32'hFFFF_FFF0, 9'h020);
    chk("R9", next_pc, 32'h0000_0010);
    apply(4'd8, 5'b00100, 32'hFFFF_FFFE, 9'h1FF);
    chk("R9", next_pc, 32'h0);
    apply(4'd13, 5'b10000, 32'h40, 9'h1FE);
    chk("R7", set_val, 32'd1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule